// File: doc/BRIEF.md
# Link Partner Parallel Detection Controller

This block decides what kind of Ethernet link partner sits on the far end of the cable while the local side is sending fast link pulse (FLP) bursts. Four per-clock detector flags feed it: received FLP bursts, normal link pulses (NLP), scrambled 100M idle symbols and raw signal energy. Each flag must stay high for a set number of cycles before it counts. A listening window of fixed length collects the qualified flags. When the window closes, the controller picks one of five outcomes and writes the matching status and partner-ability bits. For a partner that cannot auto-negotiate, it then drives an enable for exactly one technology.

Outcomes and enables hold until reset or until a restart pulse. A restart clears every result and reopens the window. The block also records remote fault indications in both directions. A fault reported by the partner is latched into four status locations. A locally seen link fault is latched into the advertised-fault bit that goes out to the partner. A small read port exposes the bits at fixed register addresses.

Top module: `apd_ctrl`

## Requirements
- R1: While reset is held, both enables are low, the strobe is low and every register address reads zero; reset is synchronous and active high.
- R2: A detector flag counts only after it has been high on QUAL_CYCLES consecutive clock edges inside the listening window; shorter bursts have no effect on the outcome.
- R3: If only NLP qualified in a window, address 5 bit 5 and address 1 bit 5 (complete) read one, address 6 bit 0 reads zero, and only `link10_en` is high.
- R4: If only 100M idles qualified, address 5 bit 7 and address 1 bit 5 read one, address 6 bit 0 reads zero, and only `link100_en` is high.
- R5: If FLP bursts qualified, address 6 bit 0 reads one, no enable is raised and address 1 bit 5 stays zero, whatever else was seen.
- R6: If nothing qualified, not even energy, address 17 bit 3 reads one, no enable is raised and address 1 bit 5 stays zero.
- R7: If both NLP and 100M idles qualified without FLP, address 6 bit 4 reads one, no enable is raised and address 1 bit 5 stays zero.
- R8: If only energy qualified, no outcome is taken: the window reopens with no strobe and no register change.
- R9: A remote fault pulse sets address 1 bit 4, address 5 bit 13, address 17 bit 1 and address 19 bit 13.
- R10: A local fault pulse sets address 4 bit 13.
- R11: Each decision raises `result_stb` for exactly one cycle, in the first cycle of the outcome, with `result_code` 1 = 10M, 2 = 100M, 3 = autonegotiating partner, 4 = no signal, 5 = detection fault, and 0 outside an outcome.
- R12: Results, fault bits and enables hold until a restart pulse. The restart clears all of them from the next cycle and starts a fresh window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | One-cycle pulse: clear results and relisten |
| flp_seen | input | 1 | FLP burst detector flag |
| nlp_seen | input | 1 | Normal link pulse detector flag |
| idle_seen | input | 1 | Scrambled 100M idle detector flag |
| energy_seen | input | 1 | Receive energy detector flag |
| rem_fault | input | 1 | Partner reports a remote fault |
| loc_fault | input | 1 | Local link fault detected |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 16 | Register read data |
| link10_en | output | 1 | Enable 10M half-duplex |
| link100_en | output | 1 | Enable 100M half-duplex |
| result_stb | output | 1 | One-cycle decision strobe |
| result_code | output | 3 | Current outcome code |

## Verification
Two situations are hard to reach from the ports. The first is a flag that toggles just below the qualification length while energy is present. The second is energy that never resolves into a recognised pattern. In both, the decision must be withheld across several windows. The stimulus drives a link pulse flag high for one cycle less than the threshold, then low for a cycle, repeating over three windows. It then holds energy alone for three windows and checks that no strobe has appeared. After that it releases the flags and checks that exactly one decision follows.

// File: rtl/apd_pkg.sv
package apd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_LISTEN, ST_RESOLVE, ST_LINK_10,
        ST_LINK_100, ST_AUTONEG, ST_NO_SIGNAL, ST_FAULT
    } apd_state_e;

    typedef enum logic [2:0] {
        OC_NONE     = 3'd0,
        OC_10M      = 3'd1,
        OC_100M     = 3'd2,
        OC_AN       = 3'd3,
        OC_QUIET    = 3'd4,
        OC_CONFLICT = 3'd5
    } apd_outcome_e;

    localparam int NUM_DET    = 4;
    localparam int DET_FLP    = 0;
    localparam int DET_NLP    = 1;
    localparam int DET_IDLE   = 2;
    localparam int DET_ENERGY = 3;

    localparam logic [4:0] A_STATUS  = 5'd1;
    localparam logic [4:0] A_ADVERT  = 5'd4;
    localparam logic [4:0] A_PARTNER = 5'd5;
    localparam logic [4:0] A_EXPAND  = 5'd6;
    localparam logic [4:0] A_QUICK   = 5'd17;
    localparam logic [4:0] A_AUX     = 5'd19;

    typedef struct packed {
        logic complete;
        logic lp_10hd;
        logic lp_100hd;
        logic lp_an_able;
        logic pd_fault;
        logic no_signal;
        logic rem_fault;
        logic adv_fault;
    } apd_bits_t;

    function automatic apd_outcome_e classify(input logic [NUM_DET-1:0] s);
        if (s[DET_FLP])                  return OC_AN;
        if (s[DET_NLP] && s[DET_IDLE])   return OC_CONFLICT;
        if (s[DET_NLP])                  return OC_10M;
        if (s[DET_IDLE])                 return OC_100M;
        if (s[DET_ENERGY])               return OC_NONE;
        return OC_QUIET;
    endfunction

    function automatic apd_state_e state_for(input apd_outcome_e oc);
        case (oc)
            OC_10M:      return ST_LINK_10;
            OC_100M:     return ST_LINK_100;
            OC_AN:       return ST_AUTONEG;
            OC_QUIET:    return ST_NO_SIGNAL;
            OC_CONFLICT: return ST_FAULT;
            default:     return ST_LISTEN;
        endcase
    endfunction

    function automatic apd_outcome_e code_of(input apd_state_e st);
        case (st)
            ST_LINK_10:   return OC_10M;
            ST_LINK_100:  return OC_100M;
            ST_AUTONEG:   return OC_AN;
            ST_NO_SIGNAL: return OC_QUIET;
            ST_FAULT:     return OC_CONFLICT;
            default:      return OC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/apd_qualifier.sv
module apd_qualifier #(
    parameter int QUAL_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic flag,
    output logic seen
);
    localparam int CW = (QUAL_CYCLES < 2) ? 1 : $clog2(QUAL_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            run_cnt <= '0;
            seen    <= 1'b0;
        end else if (flag && en) begin
            if (run_cnt == LAST) seen <= 1'b1;
            else                 run_cnt <= run_cnt + 1'b1;
        end else begin
            run_cnt <= '0;
        end
    end

    // R2
    qualified_by_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(seen) |-> $past(flag) && $past(en));

endmodule

// File: rtl/apd_window.sv
module apd_window #(
    parameter int WIN_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int WW = (WIN_CYCLES < 2) ? 1 : $clog2(WIN_CYCLES);
    localparam logic [WW-1:0] LAST = WW'(WIN_CYCLES - 1);

    logic [WW-1:0] tick;

    always_ff @(posedge clk) begin
        if (rst || !run)      tick <= '0;
        else if (tick == LAST) tick <= '0;
        else                  tick <= tick + 1'b1;
    end

    assign expire = run && (tick == LAST);

    // R8
    window_restarts_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> (tick == '0));

endmodule

// File: rtl/apd_fsm.sv
module apd_fsm
    import apd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic               win_expire,
    input  logic [NUM_DET-1:0] seen,
    output logic               listening,
    output logic               det_clr,
    output logic               res_fire,
    output apd_outcome_e       res_code,
    output logic               strobe,
    output logic               en10,
    output logic               en100,
    output apd_outcome_e       cur_code
);
    apd_state_e state, state_nx;

    assign res_code = classify(seen);
    assign res_fire = (state == ST_RESOLVE) && (res_code != OC_NONE) && !restart;

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:    state_nx = ST_LISTEN;
            ST_LISTEN:  if (win_expire) state_nx = ST_RESOLVE;
            ST_RESOLVE: state_nx = state_for(res_code);
            default:    state_nx = state;
        endcase
        if (restart) state_nx = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            strobe <= 1'b0;
        end else begin
            state  <= state_nx;
            strobe <= res_fire;
        end
    end

    assign listening = (state == ST_LISTEN);
    assign det_clr   = (state == ST_IDLE) ||
                       ((state == ST_RESOLVE) && (res_code == OC_NONE));
    assign en10      = (state == ST_LINK_10);
    assign en100     = (state == ST_LINK_100);
    assign cur_code  = code_of(state);

    // R3
    single_tech_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({en10, en100}));

    // R11
    strobe_entry_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |-> (cur_code != OC_NONE) && ($past(state) == ST_RESOLVE));

endmodule

// File: rtl/apd_regs.sv
module apd_regs
    import apd_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         res_fire,
    input  apd_outcome_e res_code,
    input  logic         rem_fault,
    input  logic         loc_fault,
    input  logic [4:0]   rd_addr,
    output logic [15:0]  rd_data
);
    apd_bits_t b;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            b <= '0;
        end else begin
            if (rem_fault) b.rem_fault <= 1'b1;
            if (loc_fault) b.adv_fault <= 1'b1;
            if (res_fire) begin
                case (res_code)
                    OC_10M: begin
                        b.complete   <= 1'b1;
                        b.lp_10hd    <= 1'b1;
                        b.lp_an_able <= 1'b0;
                    end
                    OC_100M: begin
                        b.complete   <= 1'b1;
                        b.lp_100hd   <= 1'b1;
                        b.lp_an_able <= 1'b0;
                    end
                    OC_AN:       b.lp_an_able <= 1'b1;
                    OC_QUIET:    b.no_signal  <= 1'b1;
                    OC_CONFLICT: b.pd_fault   <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_STATUS: begin
                rd_data[5] = b.complete;
                rd_data[4] = b.rem_fault;
            end
            A_ADVERT:  rd_data[13] = b.adv_fault;
            A_PARTNER: begin
                rd_data[5]  = b.lp_10hd;
                rd_data[7]  = b.lp_100hd;
                rd_data[13] = b.rem_fault;
            end
            A_EXPAND: begin
                rd_data[0] = b.lp_an_able;
                rd_data[4] = b.pd_fault;
            end
            A_QUICK: begin
                rd_data[3] = b.no_signal;
                rd_data[1] = b.rem_fault;
            end
            A_AUX:     rd_data[13] = b.rem_fault;
            default: ;
        endcase
    end

    // R7
    fault_not_complete_chk: assert property (@(posedge clk) disable iff (rst)
        b.pd_fault |-> !b.complete);

    // R12
    restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (b == '0));

endmodule

// File: rtl/apd_ctrl.sv
module apd_ctrl
    import apd_pkg::*;
#(
    parameter int QUAL_CYCLES = 8,
    parameter int WIN_CYCLES  = 50000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        restart,
    input  logic        flp_seen,
    input  logic        nlp_seen,
    input  logic        idle_seen,
    input  logic        energy_seen,
    input  logic        rem_fault,
    input  logic        loc_fault,
    input  logic [4:0]  rd_addr,
    output logic [15:0] rd_data,
    output logic        link10_en,
    output logic        link100_en,
    output logic        result_stb,
    output logic [2:0]  result_code
);
    logic [NUM_DET-1:0] raw, seen;
    logic               listening, det_clr, win_expire, res_fire;
    apd_outcome_e       res_code, cur_code;

    always_comb begin
        raw             = '0;
        raw[DET_FLP]    = flp_seen;
        raw[DET_NLP]    = nlp_seen;
        raw[DET_IDLE]   = idle_seen;
        raw[DET_ENERGY] = energy_seen;
    end

    for (genvar g = 0; g < NUM_DET; g++) begin : g_qual
        apd_qualifier #(.QUAL_CYCLES(QUAL_CYCLES)) u_q (
            .clk (clk),
            .rst (rst),
            .clr (det_clr || restart),
            .en  (listening),
            .flag(raw[g]),
            .seen(seen[g])
        );
    end

    apd_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
        .clk   (clk),
        .rst   (rst),
        .run   (listening && !restart),
        .expire(win_expire)
    );

    apd_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .win_expire(win_expire),
        .seen      (seen),
        .listening (listening),
        .det_clr   (det_clr),
        .res_fire  (res_fire),
        .res_code  (res_code),
        .strobe    (result_stb),
        .en10      (link10_en),
        .en100     (link100_en),
        .cur_code  (cur_code)
    );

    apd_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .res_fire (res_fire),
        .res_code (res_code),
        .rem_fault(rem_fault),
        .loc_fault(loc_fault),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    assign result_code = cur_code;

endmodule

// File: tb/sim_apd_ctrl.sv
`timescale 1ns/1ps
module sim_apd_ctrl;
    localparam int QUAL = 4;
    localparam int WIN  = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic restart = 1'b0;
    logic flp = 1'b0, nlp = 1'b0, idl = 1'b0, nrg = 1'b0;
    logic rfault = 1'b0, lfault = 1'b0;
    logic [4:0]  rd_addr = 5'd0;
    logic [15:0] rd_data;
    logic en10, en100, stb;
    logic [2:0] code;

    int vectors = 0;
    int fails   = 0;
    int strobes = 0;
    int base    = 0;
    logic [2:0] last_code = 3'd0;

    always #2.5 clk = ~clk;

    apd_ctrl #(.QUAL_CYCLES(QUAL), .WIN_CYCLES(WIN)) u0 (
        .clk(clk), .rst(rst), .restart(restart),
        .flp_seen(flp), .nlp_seen(nlp), .idle_seen(idl), .energy_seen(nrg),
        .rem_fault(rfault), .loc_fault(lfault),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .link10_en(en10), .link100_en(en100),
        .result_stb(stb), .result_code(code)
    );

    always @(negedge clk) begin
        if (!rst && stb) begin
            strobes   <= strobes + 1;
            last_code <= code;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic set_flags(input logic f, input logic n, input logic i, input logic e);
        @(negedge clk);
        flp = f; nlp = n; idl = i; nrg = e;
    endtask

    task automatic do_restart();
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        base = strobes;
    endtask

    task automatic wait_win(input int n);
        repeat (n * (WIN + 4) + QUAL + 8) @(negedge clk);
        #0.1;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R1 en10", {15'd0, en10}, 16'd0);
        chk("R1 en100", {15'd0, en100}, 16'd0);
        chk("R1 strobe", {15'd0, stb}, 16'd0);
        foreach (apd_pkg::A_STATUS[i]) ;
        rd(5'd1, d);  chk("R1 addr1", d, 16'd0);
        rd(5'd4, d);  chk("R1 addr4", d, 16'd0);
        rd(5'd5, d);  chk("R1 addr5", d, 16'd0);
        rd(5'd6, d);  chk("R1 addr6", d, 16'd0);
        rd(5'd17, d); chk("R1 addr17", d, 16'd0);
        rd(5'd19, d); chk("R1 addr19", d, 16'd0);
    endtask

    task automatic t_10m();
        logic [15:0] d;
        set_flags(0, 1, 0, 1);
        do_restart();
        wait_win(1);
        rd(5'd5, d); chk("R3 partner bits", d, 16'h0020);
        rd(5'd6, d); chk("R3 expansion", d, 16'h0000);
        rd(5'd1, d); chk("R3 complete", d, 16'h0020);
        chk("R3 enables", {14'd0, en100, en10}, 16'b01);
        chk("R11 strobe count", 16'(strobes - base), 16'd1);
        chk("R11 code 10M", {13'd0, last_code}, 16'd1);
    endtask

    task automatic t_hold_restart();
        logic [15:0] d;
        set_flags(0, 0, 1, 1);
        wait_win(2);
        chk("R12 hold en10", {14'd0, en100, en10}, 16'b01);
        rd(5'd5, d); chk("R12 hold partner", d, 16'h0020);
        do_restart();
        #0.1;
        chk("R12 enables cleared", {14'd0, en100, en10}, 16'b00);
        rd(5'd1, d); chk("R12 status cleared", d, 16'h0000);
        wait_win(1);
        rd(5'd5, d); chk("R4 partner bits", d, 16'h0080);
        rd(5'd1, d); chk("R4 complete", d, 16'h0020);
        rd(5'd6, d); chk("R4 expansion", d, 16'h0000);
        chk("R4 enables", {14'd0, en100, en10}, 16'b10);
        chk("R11 code 100M", {13'd0, last_code}, 16'd2);
    endtask

    task automatic t_an();
        logic [15:0] d;
        set_flags(1, 1, 1, 1);
        do_restart();
        wait_win(1);
        rd(5'd6, d); chk("R5 expansion", d, 16'h0001);
        rd(5'd1, d); chk("R5 no complete", d, 16'h0000);
        chk("R5 enables", {14'd0, en100, en10}, 16'b00);
        chk("R11 code AN", {13'd0, last_code}, 16'd3);
        chk("R11 code held", {13'd0, code}, 16'd3);
    endtask

    task automatic t_quiet();
        logic [15:0] d;
        set_flags(0, 0, 0, 0);
        do_restart();
        wait_win(1);
        rd(5'd17, d); chk("R6 no signal", d, 16'h0008);
        rd(5'd1, d);  chk("R6 no complete", d, 16'h0000);
        chk("R6 enables", {14'd0, en100, en10}, 16'b00);
        chk("R11 code quiet", {13'd0, last_code}, 16'd4);
    endtask

    task automatic t_conflict();
        logic [15:0] d;
        set_flags(0, 1, 1, 1);
        do_restart();
        wait_win(1);
        rd(5'd6, d); chk("R7 fault bit", d, 16'h0010);
        rd(5'd1, d); chk("R7 no complete", d, 16'h0000);
        chk("R7 enables", {14'd0, en100, en10}, 16'b00);
        chk("R11 code fault", {13'd0, last_code}, 16'd5);
    endtask

    task automatic t_energy();
        logic [15:0] d;
        set_flags(0, 0, 0, 1);
        do_restart();
        wait_win(3);
        chk("R8 no strobe", 16'(strobes - base), 16'd0);
        chk("R8 code none", {13'd0, code}, 16'd0);
        rd(5'd17, d); chk("R8 no signal clear", d, 16'h0000);
        set_flags(0, 0, 0, 0);
        wait_win(2);
        chk("R8 reopened once", 16'(strobes - base), 16'd1);
        chk("R8 later quiet", {13'd0, last_code}, 16'd4);
    endtask

    task automatic t_short();
        logic [15:0] d;
        set_flags(0, 0, 0, 1);
        do_restart();
        for (int i = 0; i < 3 * (WIN + 4); i++) begin
            nlp = ((i % QUAL) != (QUAL - 1));
            @(negedge clk);
        end
        #0.1;
        chk("R2 short pulses ignored", 16'(strobes - base), 16'd0);
        rd(5'd5, d); chk("R2 partner clear", d, 16'h0000);
        nlp = 1'b1;
        wait_win(2);
        chk("R2 steady qualifies", {14'd0, en100, en10}, 16'b01);
    endtask

    task automatic t_faults();
        logic [15:0] d;
        set_flags(0, 0, 0, 0);
        do_restart();
        @(negedge clk); rfault = 1'b1; lfault = 1'b1;
        @(negedge clk); rfault = 1'b0; lfault = 1'b0;
        #0.1;
        rd(5'd1, d);  chk("R9 status fault", d & 16'h0010, 16'h0010);
        rd(5'd5, d);  chk("R9 partner fault", d & 16'h2000, 16'h2000);
        rd(5'd17, d); chk("R9 quick fault", d & 16'h0002, 16'h0002);
        rd(5'd19, d); chk("R9 aux fault", d & 16'h2000, 16'h2000);
        rd(5'd4, d);  chk("R10 advert fault", d, 16'h2000);
        wait_win(1);
        rd(5'd4, d);  chk("R12 fault holds", d, 16'h2000);
        do_restart();
        #0.1;
        rd(5'd4, d);  chk("R12 advert cleared", d, 16'h0000);
        rd(5'd19, d); chk("R12 aux cleared", d, 16'h0000);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_10m();
        t_hold_restart();
        t_an();
        t_quiet();
        t_conflict();
        t_energy();
        t_short();
        t_faults();
        finish_run();
    end

    initial begin
        #(200000 * 5);
        vectors++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

endmodule